// File: doc/BRIEF.md
# Shaped Envelope Generator

This block produces a 4-bit amplitude envelope. The envelope moves in sixteen-level ramps, and the ramps are timed by a programmable 16-bit period. A 4-bit shape word picks the contour. The ramp can rise or fall. It can play once and then go silent, repeat as a sawtooth, repeat as a triangle, or freeze at one end. A one-cycle restart pulse, sent when software writes the shape word, starts a new envelope from its first level. All timing advances only on cycles where the master clock enable is high.

The 4-bit output drives the amplitude selection logic of a tone channel. Register decoding and digital-to-analog conversion are handled outside this block.

Top module: `env_shaper`

## Requirements
- R1: After reset the output is 0, and it stays 0 whatever the clock enable does until the first restart pulse.
- R2: On the cycle after a restart pulse, the output is 0 if Attack (shape bit 2) is 1, or 15 if Attack is 0. The restart also clears the tick prescaler and the period counter.
- R3: Each envelope level lasts exactly period × 16 enabled ticks, where period is the 16-bit input. A period of 0 gives the same timing as a period of 1.
- R4: Cycles with the clock enable low do not advance the envelope timing.
- R5: With Continue (shape bit 3) at 0, the envelope runs one ramp, up if Attack is 1 or down if Attack is 0. It then goes to 0 and stays there. Alternate (bit 1) and Hold (bit 0) have no effect.
- R6: With Continue 1, Hold 0 and Alternate 0, the ramp repeats without end. It wraps around and keeps the same direction (sawtooth).
- R7: With Continue 1, Hold 0 and Alternate 1, the ramp repeats and its direction reverses after every 16 levels (triangle).
- R8: With Continue 1 and Hold 1, the output freezes once the first ramp ends. It holds the last value of that ramp if Alternate is 0, or the opposite end value if Alternate is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Master clock enable; timing advances only when high |
| period | input | 16 | Envelope period (level duration in units of 16 ticks) |
| shape | input | 4 | {Continue, Attack, Alternate, Hold} |
| restart | input | 1 | One-cycle pulse that starts a new envelope |
| env_out | output | 4 | Envelope level E3..E0 |

## Verification
A prescaler or period counter in the wrong state moves every following level edge. The error shows within one level duration as an output that changes one or more ticks early or late. A wrong direction flag or ramp position shows at the next level step as a value that does not match the arithmetic contour. A hold flag set at the wrong time shows when the first ramp ends: the output freezes at the wrong value or keeps moving. Every enabled tick is compared, so any of these faults is reported within a single level period.

// File: rtl/env_pkg.sv
package env_pkg;
  localparam int unsigned LVL_W = 4;
  localparam int unsigned PRE_W = 4;

  typedef struct packed {
    logic cont;
    logic attack;
    logic alt;
    logic hold;
  } shape_t;

  // period of 0 behaves like 1
  function automatic logic [15:0] eff_period(input logic [15:0] p);
    return (p == 16'd0) ? 16'd1 : p;
  endfunction

  // level seen at ramp position pos in the given direction
  function automatic logic [LVL_W-1:0] ramp_level(input logic [LVL_W-1:0] pos, input logic up);
    return up ? pos : ~pos;
  endfunction

  // frozen value once a ramp has finished
  function automatic logic [LVL_W-1:0] end_level(input shape_t s, input logic up);
    if (!s.cont) return '0;
    return (up ^ s.alt) ? '1 : '0;
  endfunction
endpackage

// File: rtl/env_timer.sv
module env_timer #(
  parameter int unsigned PER_W = 16,
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             pre_wrap,
  output logic             step_evt
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] per_last;

  assign per_last = env_pkg::eff_period(period) - 1'b1;
  assign pre_wrap = tick_en && !restart && (pre_q == PRE_LAST);
  assign step_evt = pre_wrap && (per_q >= per_last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_q <= '0;
      per_q <= '0;
    end else if (tick_en) begin
      pre_q <= pre_q + 1'b1;
      if (pre_wrap) per_q <= step_evt ? '0 : per_q + 1'b1;
    end
  end
endmodule

// File: rtl/env_contour.sv
module env_contour
  import env_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step_evt,
  input  shape_t           shape,
  output logic             held,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] pos_q;
  logic             up_q;
  logic             held_q;
  logic [LVL_W-1:0] hold_lvl_q;
  logic             ramp_end;

  assign ramp_end = (pos_q == '1);
  assign held     = held_q;
  assign level    = held_q ? hold_lvl_q : ramp_level(pos_q, up_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      up_q       <= 1'b0;
      held_q     <= 1'b1;
      hold_lvl_q <= '0;
    end else if (restart) begin
      pos_q      <= '0;
      up_q       <= shape.attack;
      held_q     <= 1'b0;
      hold_lvl_q <= '0;
    end else if (step_evt && !held_q) begin
      if (!ramp_end) begin
        pos_q <= pos_q + 1'b1;
      end else if (!shape.cont || shape.hold) begin
        held_q     <= 1'b1;
        hold_lvl_q <= end_level(shape, up_q);
      end else begin
        pos_q <= '0;
        if (shape.alt) up_q <= ~up_q;
      end
    end
  end
endmodule

// File: rtl/env_shaper.sv
module env_shaper #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [PER_W-1:0] period,
  input  logic [3:0]       shape,
  input  logic             restart,
  output logic [3:0]       env_out
);
  logic pre_wrap;
  logic step_evt;
  logic held;

  env_timer #(.PER_W(PER_W), .PRE_W(env_pkg::PRE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
    .period(period), .pre_wrap(pre_wrap), .step_evt(step_evt)
  );

  env_contour u_contour (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step_evt(step_evt),
    .shape(env_pkg::shape_t'(shape)), .held(held), .level(env_out)
  );
endmodule

// File: rtl/env_shaper_chk.sv
module env_shaper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic [3:0] shape,
  input logic       restart,
  input logic [3:0] env_out,
  input logic       step_evt,
  input logic       pre_wrap,
  input logic       held
);
  a_r2_restart_start: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> env_out == ($past(shape[2]) ? 4'd0 : 4'd15));

  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(env_out));

  a_r3_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !restart) |=> $stable(env_out));

  a_r3_step_on_prescale: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> pre_wrap);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !restart) |=> $stable(env_out));
endmodule

bind env_shaper env_shaper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .shape(shape),
  .restart(restart), .env_out(env_out), .step_evt(step_evt),
  .pre_wrap(pre_wrap), .held(held)
);

// File: tb/tb_env_shaper.sv
`timescale 1ns/1ps
module tb_env_shaper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [15:0] period = 16'd1;
  logic [3:0]  shape = 4'd0;
  logic        restart = 1'b0;
  logic [3:0]  env_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  env_shaper dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period(period),
    .shape(shape), .restart(restart), .env_out(env_out)
  );

  task automatic check(input string tag, input int exp);
    n_cmp++;
    if (env_out !== exp[3:0]) begin
      n_bad++;
      $display("FAIL %s: env_out=%0d expected=%0d (shape=%b period=%0d)",
               tag, env_out, exp, shape, period);
    end
  endtask

  // contour computed from level index s
  function automatic int model(input int s, input bit [3:0] sh);
    int r = s / 16;
    int p = s % 16;
    bit up = sh[2];
    if (!sh[3]) return (r == 0) ? (up ? p : 15 - p) : 0;
    if (sh[0]) return (r == 0) ? (up ? p : 15 - p) : ((up ^ sh[1]) ? 15 : 0);
    if (sh[1] && (r % 2 == 1)) up = !up;
    return up ? p : 15 - p;
  endfunction

  task automatic run(input bit [3:0] sh, input int per, input bit gate, input string tag);
    int peff = (per == 0) ? 1 : per;
    int n = 0;
    int total = 36 * 16 * peff;
    int cyc = 0;
    @(negedge clk);
    shape = sh; period = 16'(per); restart = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check("R2", sh[2] ? 0 : 15);
    while (n < total) begin
      bit en = gate ? ((cyc % 3) != 2) : 1'b1;
      tick_en = en;
      @(posedge clk);
      if (en) n++;
      cyc++;
      @(negedge clk);
      check(tag, model(n / (16 * peff), sh));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check("R1", 0);
    tick_en = 1'b1;
    repeat (300) @(negedge clk);
    check("R1", 0);
    for (int s = 0; s < 16; s++) begin
      bit [3:0] sh = 4'(s);
      string tg;
      if (!sh[3]) tg = "R5";
      else if (sh[0]) tg = "R8";
      else if (sh[1]) tg = "R7";
      else tg = "R6";
      run(sh, 1, 1'b0, tg);
      run(sh, 0, 1'b0, "R3");
      run(sh, 3, 1'b1, "R4");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule